// File: doc/BRIEF.md
# Dual-Field PCM Highway Interface

This block is the serial time-slot port of a telephony line circuit. It runs on the highway bit clock (nominally 2.048 MHz, so one frame of the 8 kHz frame sync spans 256 bit periods). Each frame carries two independent 8-bit fields in each direction. A rising edge of the frame sync opens the voice field, and a falling edge opens the control field. In the voice field the block shifts out a voice sample and shifts in a voice sample. In the control field it shifts out a supervision (scan) byte and shifts in a control byte.

On the transmit side the outgoing voice and scan bytes come from parallel inputs. Each is captured at the sync edge that opens its field. The transmit line is held low outside the two windows, and a separate enable output marks exactly the bit periods in which it carries data. On the receive side the line is sampled on the falling clock edge. Each completed byte is presented on its own parallel output together with a one-cycle valid pulse. The frame sync must stay at each level for at least eight bit periods, so the two windows never overlap. Reset is an active-low input with asynchronous assertion and synchronous release. While it is low, the transmit output flop is held cleared.

Top module: `pcm_hw_if`

## Requirements
- R1: A rising edge of `fsync` (sampled high on a rising `clk` edge after being low on the previous one) captures `tx_voice`. That byte is sent MSB first on `hw_tx`, one bit per period, with bit 7 in the period that follows the detecting edge.
- R2: A falling edge of `fsync`, detected in the same way, captures `tx_scan`. That byte is sent MSB first on `hw_tx` with the same timing.
- R3: `hw_tx_en` is high for exactly the 8 periods of each field and low otherwise. `hw_tx` is low whenever `hw_tx_en` is low.
- R4: In a field opened by a rising edge, `hw_rx` is sampled on the falling `clk` edge of each of the 8 field periods, MSB first. In the period right after the field, `rx_voice` holds the byte and `rx_voice_vld` is high for exactly one cycle.
- R5: In a field opened by a falling edge, the received byte appears on `rx_ctrl` with a one-cycle `rx_ctrl_vld` pulse, using the same timing as R4. `rx_voice_vld` and `rx_ctrl_vld` are never high together.
- R6: A change on `tx_voice` or `tx_scan` after the opening edge has no effect on the bits still to be sent in that field.
- R7: While `rst_n` is low, `hw_tx` and `hw_tx_en` are low at once, even in the middle of a field. An interrupted field produces no receive valid pulse.
- R8: Holding `fsync` at a steady level starts no further field: `hw_tx_en` stays low after the 8 periods of the field that the edge opened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Highway bit clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| fsync | input | 1 | Frame sync; rising edge opens voice field, falling edge opens control field |
| hw_rx | input | 1 | Receive highway serial data |
| tx_voice | input | 8 | Voice byte to transmit in the next voice field |
| tx_scan | input | 8 | Supervision byte to transmit in the next control field |
| hw_tx | output | 1 | Transmit highway serial data, low when idle |
| hw_tx_en | output | 1 | High while hw_tx carries field bits |
| rx_voice | output | 8 | Last received voice byte |
| rx_voice_vld | output | 1 | One-cycle strobe for a new rx_voice |
| rx_ctrl | output | 8 | Last received control byte |
| rx_ctrl_vld | output | 1 | One-cycle strobe for a new rx_ctrl |

## Verification
The field sequencer is the one piece of state that every output depends on. If its count or its field kind were wrong, the fault would show within the same field. `hw_tx_en` would be too long or too short by the ninth period after the sync edge, the transmit bits would be out of step with the captured byte, or the valid strobe would land on the wrong receive port. A wrong receive shift path shows one cycle after the field, as a mismatched byte. A transmit capture that is not isolated from its input shows as a bit error in the second half of the field in which the input changes.

// File: rtl/pcm_hw_pkg.sv
package pcm_hw_pkg;
  // Kind of field opened by a sync edge
  typedef enum logic {
    FLD_VOICE = 1'b0,
    FLD_CTRL  = 1'b1
  } fld_e;
endpackage

// File: rtl/pcm_rst_sync.sv
module pcm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/pcm_fs_edge.sv
module pcm_fs_edge
  import pcm_hw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fsync,
  output logic start,
  output fld_e start_kind
);
  logic fs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fs_q <= 1'b0;
    else        fs_q <= fsync;
  end

  assign start      = fsync ^ fs_q;
  assign start_kind = fsync ? FLD_VOICE : FLD_CTRL;
endmodule

// File: rtl/pcm_field_seq.sv
module pcm_field_seq
  import pcm_hw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  fld_e start_kind,
  output logic busy,
  output fld_e kind,
  output logic finish
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_d;
  fld_e          kind_q, kind_d;

  assign finish = busy && (cnt_q == LAST);

  always_comb begin
    busy_d = busy;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      kind_d = start_kind;
    end else if (busy) begin
      if (finish) busy_d = 1'b0;
      else        cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
      kind_q <= FLD_VOICE;
    end else begin
      busy   <= busy_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
    end
  end

  assign kind = kind_q;

  // R3
  start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && cnt_q == '0));

  // R3
  win_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !start) |=> !busy);
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift
  import pcm_hw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  fld_e          start_kind,
  input  logic          busy,
  input  logic          finish,
  input  logic [DW-1:0] voice_byte,
  input  logic [DW-1:0] scan_byte,
  output logic          hw_tx
);
  logic [DW-1:0] sh_q, sh_d, pick;
  logic          bit_d;

  assign pick = (start_kind == FLD_VOICE) ? voice_byte : scan_byte;

  always_comb begin
    sh_d  = sh_q;
    bit_d = hw_tx;
    if (start) begin
      bit_d = pick[DW-1];
      sh_d  = {pick[DW-2:0], 1'b0};
    end else if (finish) begin
      bit_d = 1'b0;
    end else if (busy) begin
      bit_d = sh_q[DW-1];
      sh_d  = {sh_q[DW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      hw_tx <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      hw_tx <= bit_d;
    end
  end
endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift
  import pcm_hw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_rx,
  input  logic          busy,
  input  logic          finish,
  input  fld_e          kind,
  output logic [DW-1:0] voice_byte,
  output logic          voice_vld,
  output logic [DW-1:0] ctrl_byte,
  output logic          ctrl_vld
);
  logic          smp_q;
  logic [DW-1:0] sh_q, sh_d, word;
  logic [DW-1:0] voice_d, ctrl_d;
  logic          voice_vld_d, ctrl_vld_d;

  // line sampled mid-period on the falling clock edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= 1'b0;
    else        smp_q <= hw_rx;
  end

  assign word = {sh_q[DW-2:0], smp_q};

  always_comb begin
    sh_d        = busy ? word : sh_q;
    voice_d     = voice_byte;
    ctrl_d      = ctrl_byte;
    voice_vld_d = 1'b0;
    ctrl_vld_d  = 1'b0;
    if (finish) begin
      if (kind == FLD_VOICE) begin
        voice_d     = word;
        voice_vld_d = 1'b1;
      end else begin
        ctrl_d      = word;
        ctrl_vld_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q       <= '0;
      voice_byte <= '0;
      ctrl_byte  <= '0;
      voice_vld  <= 1'b0;
      ctrl_vld   <= 1'b0;
    end else begin
      sh_q       <= sh_d;
      voice_byte <= voice_d;
      ctrl_byte  <= ctrl_d;
      voice_vld  <= voice_vld_d;
      ctrl_vld   <= ctrl_vld_d;
    end
  end

  // R4
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (voice_vld || ctrl_vld) |=> !(voice_vld || ctrl_vld));

  // R5
  one_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(voice_vld && ctrl_vld));
endmodule

// File: rtl/pcm_hw_if.sv
module pcm_hw_if
  import pcm_hw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync,
  input  logic          hw_rx,
  input  logic [DW-1:0] tx_voice,
  input  logic [DW-1:0] tx_scan,
  output logic          hw_tx,
  output logic          hw_tx_en,
  output logic [DW-1:0] rx_voice,
  output logic          rx_voice_vld,
  output logic [DW-1:0] rx_ctrl,
  output logic          rx_ctrl_vld
);
  logic rst_s_n;
  logic start, busy, finish;
  fld_e start_kind, kind;

  pcm_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_s_n)
  );

  pcm_fs_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .fsync      (fsync),
    .start      (start),
    .start_kind (start_kind)
  );

  pcm_field_seq #(.DW(DW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .start      (start),
    .start_kind (start_kind),
    .busy       (busy),
    .kind       (kind),
    .finish     (finish)
  );

  pcm_tx_shift #(.DW(DW)) u_tx (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .start      (start),
    .start_kind (start_kind),
    .busy       (busy),
    .finish     (finish),
    .voice_byte (tx_voice),
    .scan_byte  (tx_scan),
    .hw_tx      (hw_tx)
  );

  pcm_rx_shift #(.DW(DW)) u_rx (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .hw_rx      (hw_rx),
    .busy       (busy),
    .finish     (finish),
    .kind       (kind),
    .voice_byte (rx_voice),
    .voice_vld  (rx_voice_vld),
    .ctrl_byte  (rx_ctrl),
    .ctrl_vld   (rx_ctrl_vld)
  );

  assign hw_tx_en = busy;

  // R3
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !hw_tx_en |-> !hw_tx);
endmodule

// File: tb/tb_pcm_hw_if.sv
module tb_pcm_hw_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync = 1'b0;
  logic       hw_rx = 1'b0;
  logic [7:0] tx_voice = '0;
  logic [7:0] tx_scan = '0;
  logic       hw_tx, hw_tx_en, rx_voice_vld, rx_ctrl_vld;
  logic [7:0] rx_voice, rx_ctrl;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct packed { logic is_ctrl; logic [7:0] b; } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  pcm_hw_if dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .hw_rx(hw_rx),
    .tx_voice(tx_voice), .tx_scan(tx_scan),
    .hw_tx(hw_tx), .hw_tx_en(hw_tx_en),
    .rx_voice(rx_voice), .rx_voice_vld(rx_voice_vld),
    .rx_ctrl(rx_ctrl), .rx_ctrl_vld(rx_ctrl_vld)
  );

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
    end
  endtask

  // monitor: pops the scoreboard on every receive strobe
  logic prev_vld = 1'b0;
  always @(posedge clk) begin
    exp_t e;
    #3;
    if (rx_voice_vld || rx_ctrl_vld) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected strobe", 1, 0);
      end else begin
        e = exp_q.pop_front();
        if (e.is_ctrl) begin
          chk(rx_ctrl_vld && !rx_voice_vld, "R5 strobe port", rx_ctrl_vld, 1);
          chk(rx_ctrl == e.b, "R5 rx_ctrl byte", rx_ctrl, e.b);
        end else begin
          chk(rx_voice_vld && !rx_ctrl_vld, "R4 strobe port", rx_voice_vld, 1);
          chk(rx_voice == e.b, "R4 rx_voice byte", rx_voice, e.b);
        end
      end
      chk(!prev_vld, "R4 strobe width", 1, 0);
    end
    prev_vld = rx_voice_vld || rx_ctrl_vld;
  end

  // driver: one field opened by an fsync edge; changes the tx byte mid-field
  task automatic field(input logic rising, input logic [7:0] txb, input logic [7:0] rxb);
    string rq;
    rq = rising ? "R1" : "R2";
    @(posedge clk); #1;
    if (rising) tx_voice = txb; else tx_scan = txb;
    fsync = rising;
    exp_q.push_back({~rising, rxb});
    #2 chk(!hw_tx_en, "R3 en before edge", hw_tx_en, 0);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      hw_rx = rxb[7-i];
      if (i == 3) begin
        if (rising) tx_voice = ~txb; else tx_scan = ~txb;
      end
      #2;
      chk(hw_tx_en, "R3 en in window", hw_tx_en, 1);
      chk(hw_tx == txb[7-i], (i > 3) ? "R6 bit after input change" : rq, hw_tx, txb[7-i]);
    end
    @(posedge clk); #1;
    hw_rx = 1'b0;
    #2;
    chk(!hw_tx_en && !hw_tx, "R3 idle after window", {hw_tx_en, hw_tx}, 0);
    if (rising) chk(rx_voice_vld, "R4 strobe timing", rx_voice_vld, 1);
    else        chk(rx_ctrl_vld, "R5 strobe timing", rx_ctrl_vld, 1);
  endtask

  initial begin
    #(4 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #3;
    chk(!hw_tx && !hw_tx_en, "R7 reset outputs", {hw_tx, hw_tx_en}, 0);
    chk(!rx_voice_vld && !rx_ctrl_vld, "R7 reset strobes", {rx_voice_vld, rx_ctrl_vld}, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);

    field(1'b1, 8'hA5, 8'h3C);
    // R8: fsync held high, no new field
    repeat (6) begin
      @(posedge clk); #3;
      chk(!hw_tx_en, "R8 steady high", hw_tx_en, 0);
    end
    field(1'b0, 8'h96, 8'hC3);
    repeat (6) begin
      @(posedge clk); #3;
      chk(!hw_tx_en, "R8 steady low", hw_tx_en, 0);
    end
    field(1'b1, 8'hFF, 8'h00);
    field(1'b0, 8'h00, 8'hFF);
    field(1'b1, 8'h81, 8'h7E);
    field(1'b0, 8'h5A, 8'h81);

    // R7: reset in the middle of a field
    @(posedge clk); #1;
    tx_voice = 8'hFF;
    fsync = 1'b1;
    repeat (4) @(posedge clk);
    #2 chk(hw_tx_en && hw_tx, "R7 field running", {hw_tx_en, hw_tx}, 3);
    #1 rst_n = 1'b0;
    fsync = 1'b0;
    #1 chk(!hw_tx && !hw_tx_en, "R7 async clear", {hw_tx, hw_tx_en}, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (12) @(posedge clk);
    #3 chk(!hw_tx_en, "R7 no field after reset", hw_tx_en, 0);

    field(1'b1, 8'h3C, 8'hA5);
    field(1'b0, 8'hC3, 8'h69);
    repeat (4) @(posedge clk);
    #3 chk(exp_q.size() == 0, "R4 R5 all bytes delivered", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule